// File: doc/BRIEF.md
# Host Command and Video Streaming Controller

This block sits in the USB clock domain between a byte-wide host link and the pixel buffer that the camera capture logic fills. It takes single-byte commands from the host on a receive stream, and it produces every byte the host sees on a transmit stream. There are three commands: a query for the image geometry, a start of streaming and a stop of streaming. Unknown bytes are ignored.

A query is answered with a fixed five-byte packet that describes the picture format. A start command raises `stream_start` toward the capture domain. From then on the block forwards pixel bytes from the buffer to the host. Each image line is preceded by a two-byte line number, so the host can stay aligned even if it drops data. A stop command ends streaming only at the next line boundary. The transmit stream and the pixel buffer both use valid/ready handshakes, and either side may stall at any time.

The state machine has five states. `ST_IDLE` goes to `ST_PARAM` on a query and to `ST_HDR_HI` on a start. `ST_PARAM` returns to `ST_IDLE` after the fifth packet byte is accepted. `ST_HDR_HI` goes to `ST_HDR_LO`, and `ST_HDR_LO` goes to `ST_PIXELS`, each on an accepted byte. `ST_PIXELS` leaves on the last pixel byte of a line: it goes to `ST_IDLE` if a stop is pending or arrives in that cycle, and back to `ST_HDR_HI` otherwise.

Top module: `host_stream_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `tx_valid`, `pix_ready` and `stream_start` are 0.
- R2: A byte 0x01 received while idle yields exactly five transmitted bytes: the type byte, then the width as 16 bits with the high byte first, then the height as 16 bits with the high byte first.
- R3: The type byte is 0xAA when `PIX_BYTES` is 1 (grayscale) and 0xBB when `PIX_BYTES` is 2 (RGB565).
- R4: A byte 0x11 received while idle makes `stream_start` high from the next cycle on. Before each line's pixel bytes, the block sends that line's 16-bit number with the high byte first. The first line after a start is number 0.
- R5: Each line carries exactly `IMG_W*PIX_BYTES` pixel bytes. They are copied unchanged and in buffer order.
- R6: Line numbers count up by one per line and return to 0 after line `IMG_H-1`.
- R7: A byte 0x0f received while streaming takes effect after the last pixel byte of the current line is accepted. `stream_start` drops in the next cycle, and no further byte is sent.
- R8: Bytes other than the three commands are ignored. Commands arriving while the parameter packet is being sent are dropped. 0x01 and 0x11 are ignored while streaming.
- R9: When `tx_ready` is low, a pending header or parameter byte is held with `tx_valid` high. When `pix_valid` is low in the pixel phase, `tx_valid` is low. No byte is lost or repeated.
- R10: `pix_ready` is high only during the pixel phase, and then it follows `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | USB-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_data | input | 8 | Command byte from host |
| tx_data | output | 8 | Byte toward host |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Host side accepts a byte this cycle |
| pix_data | input | 8 | Byte at head of the pixel buffer |
| pix_valid | input | 1 | Pixel buffer not empty |
| pix_ready | output | 1 | Pop the pixel buffer this cycle |
| stream_start | output | 1 | Streaming active, toward capture domain |

## Verification
The bench sends a stop at several points in a line and checks that the stream always ends on a line boundary. A design that stopped at once would send a partial line, and one that ignored the stop would run on. The line counter is driven past the last line so that a missing wrap shows up as header 3 where 0 is expected. Random-looking gaps on both the transmit-ready and the buffer-valid side test for dropped or doubled bytes, which appear as a shifted pixel sequence or a wrong pop count. Commands injected during a packet and during streaming test for a packet that restarts or grows, or for a stream that is disturbed.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARAM,
        ST_HDR_HI,
        ST_HDR_LO,
        ST_PIXELS
    } hsc_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_QUERY,
        CMD_START,
        CMD_STOP
    } hsc_cmd_e;

    localparam logic [7:0] CODE_QUERY = 8'h01;
    localparam logic [7:0] CODE_START = 8'h11;
    localparam logic [7:0] CODE_STOP  = 8'h0f;

    localparam logic [7:0] TYPE_GRAY   = 8'hAA;
    localparam logic [7:0] TYPE_RGB565 = 8'hBB;

    localparam int PKT_LEN = 5;

endpackage

// File: rtl/hsc_cmd_decode.sv
module hsc_cmd_decode
    import hsc_pkg::*;
(
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output hsc_cmd_e   kind
);
    always_comb begin
        kind = CMD_NONE;
        if (in_valid) begin
            unique case (in_byte)
                CODE_QUERY: kind = CMD_QUERY;
                CODE_START: kind = CMD_START;
                CODE_STOP:  kind = CMD_STOP;
                default:    kind = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hsc_param_rom.sv
module hsc_param_rom
    import hsc_pkg::*;
#(
    parameter int IMG_W     = 640,
    parameter int IMG_H     = 480,
    parameter int PIX_BYTES = 2
) (
    input  logic [2:0] idx,
    output logic [7:0] pkt_byte
);
    localparam logic [15:0] W16 = 16'(IMG_W);
    localparam logic [15:0] H16 = 16'(IMG_H);

    logic [7:0] type_code;

    generate
        if (PIX_BYTES == 1) begin : g_gray
            assign type_code = TYPE_GRAY;
        end else begin : g_rgb
            assign type_code = TYPE_RGB565;
        end
    endgenerate

    always_comb begin
        unique case (idx)
            3'd0:    pkt_byte = type_code;
            3'd1:    pkt_byte = W16[15:8];
            3'd2:    pkt_byte = W16[7:0];
            3'd3:    pkt_byte = H16[15:8];
            3'd4:    pkt_byte = H16[7:0];
            default: pkt_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/hsc_line_tracker.sv
module hsc_line_tracker #(
    parameter int IMG_H = 480,
    parameter int BPL   = 1280
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        byte_fire,
    output logic        last_byte,
    output logic [15:0] line_num
);
    localparam int BCW = (BPL > 1) ? $clog2(BPL) : 1;
    localparam logic [BCW-1:0] LAST_IDX = BCW'(BPL - 1);
    localparam logic [15:0]    LAST_LINE = 16'(IMG_H - 1);

    logic [BCW-1:0] byte_cnt;

    assign last_byte = (byte_cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            byte_cnt <= '0;
            line_num <= '0;
        end else if (byte_fire) begin
            if (last_byte) begin
                byte_cnt <= '0;
                line_num <= (line_num == LAST_LINE) ? 16'd0 : line_num + 16'd1;
            end else begin
                byte_cnt <= byte_cnt + BCW'(1);
            end
        end
    end

    assert_line_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_num <= LAST_LINE);

    assert_line_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_fire && last_byte && !clear && line_num == LAST_LINE) |=> line_num == 16'd0);

    assert_byte_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= LAST_IDX);
endmodule

// File: rtl/host_stream_ctrl.sv
module host_stream_ctrl
    import hsc_pkg::*;
#(
    parameter int IMG_W     = 640,
    parameter int IMG_H     = 480,
    parameter int PIX_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_data,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    input  logic [7:0] pix_data,
    input  logic       pix_valid,
    output logic       pix_ready,
    output logic       stream_start
);
    localparam int BPL = IMG_W * PIX_BYTES;
    localparam logic [2:0] PKT_LAST = 3'(PKT_LEN - 1);

    hsc_state_e state, nstate;
    hsc_cmd_e   kind;
    logic [2:0] param_idx;
    logic       stop_pend;
    logic       stream_q;
    logic [7:0] rom_byte;
    logic [15:0] line_num;
    logic       last_byte;
    logic       tx_fire;
    logic       pix_fire;
    logic       streaming_n;

    hsc_cmd_decode u_dec (
        .in_valid (cmd_valid),
        .in_byte  (cmd_data),
        .kind     (kind)
    );

    hsc_param_rom #(
        .IMG_W     (IMG_W),
        .IMG_H     (IMG_H),
        .PIX_BYTES (PIX_BYTES)
    ) u_rom (
        .idx      (param_idx),
        .pkt_byte (rom_byte)
    );

    hsc_line_tracker #(
        .IMG_H (IMG_H),
        .BPL   (BPL)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_IDLE),
        .byte_fire (pix_fire),
        .last_byte (last_byte),
        .line_num  (line_num)
    );

    assign tx_fire  = tx_valid && tx_ready;
    assign pix_fire = (state == ST_PIXELS) && tx_fire;
    assign streaming_n = (nstate == ST_HDR_HI) || (nstate == ST_HDR_LO) || (nstate == ST_PIXELS);

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (kind == CMD_QUERY)      nstate = ST_PARAM;
                else if (kind == CMD_START) nstate = ST_HDR_HI;
            end
            ST_PARAM: begin
                if (tx_fire && param_idx == PKT_LAST) nstate = ST_IDLE;
            end
            ST_HDR_HI: begin
                if (tx_fire) nstate = ST_HDR_LO;
            end
            ST_HDR_LO: begin
                if (tx_fire) nstate = ST_PIXELS;
            end
            ST_PIXELS: begin
                if (tx_fire && last_byte)
                    nstate = (stop_pend || kind == CMD_STOP) ? ST_IDLE : ST_HDR_HI;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            param_idx <= '0;
            stop_pend <= 1'b0;
            stream_q  <= 1'b0;
        end else begin
            state    <= nstate;
            stream_q <= streaming_n;
            if (state == ST_IDLE)
                param_idx <= '0;
            else if (state == ST_PARAM && tx_fire)
                param_idx <= param_idx + 3'd1;
            if (state == ST_IDLE)
                stop_pend <= 1'b0;
            else if (state != ST_PARAM && kind == CMD_STOP)
                stop_pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        pix_ready = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PARAM: begin
                tx_valid = 1'b1;
                tx_data  = rom_byte;
            end
            ST_HDR_HI: begin
                tx_valid = 1'b1;
                tx_data  = line_num[15:8];
            end
            ST_HDR_LO: begin
                tx_valid = 1'b1;
                tx_data  = line_num[7:0];
            end
            ST_PIXELS: begin
                tx_valid  = pix_valid;
                tx_data   = pix_data;
                pix_ready = tx_ready;
            end
            default: ;
        endcase
    end

    assign stream_start = stream_q;

    assert_pix_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> stream_start);

    assert_hold_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && state != ST_PIXELS) |=> (tx_valid && $stable(tx_data)));

    assert_stop_on_line_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stream_start) |-> $past(pix_fire && last_byte));

    assert_pkt_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARAM) |-> (param_idx <= PKT_LAST));

    assert_start_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && kind == CMD_START) |=> (stream_start && tx_valid));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && kind == CMD_NONE) |=> !tx_valid);
endmodule

// File: tb/tb_host_stream_ctrl.sv
`timescale 1ns/1ps
module tb_host_stream_ctrl;
    localparam int W = 5;
    localparam int H = 3;
    localparam int BPL = W * 2;
    localparam int LINE_LEN = BPL + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic tx_ready = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic pix_valid = 1'b0;
    logic [7:0] tx_data, g_tx_data;
    logic tx_valid, g_tx_valid, pix_ready, g_pix_ready, stream_start, g_stream_start;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    bit stall_tx = 0;
    bit gap_pix = 0;
    logic [7:0] pv = 8'h00;
    logic [7:0] q[$];
    logic [7:0] qg[$];

    always #2.5 clk = ~clk;

    host_stream_ctrl #(.IMG_W(W), .IMG_H(H), .PIX_BYTES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .stream_start(stream_start));

    host_stream_ctrl #(.IMG_W(W), .IMG_H(H), .PIX_BYTES(1)) dut_gray (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .tx_data(g_tx_data), .tx_valid(g_tx_valid), .tx_ready(tx_ready),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(g_pix_ready),
        .stream_start(g_stream_start));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic cyc(input bit cv, input logic [7:0] cd);
        @(negedge clk);
        cmd_valid = cv;
        cmd_data  = cd;
        tx_ready  = stall_tx ? (cycle % 3 != 0) : 1'b1;
        pix_valid = gap_pix ? (cycle % 4 != 1) : 1'b1;
        pix_data  = pv;
        #1;
        if (rst_n && tx_valid && tx_ready) q.push_back(tx_data);
        if (rst_n && g_tx_valid && tx_ready) qg.push_back(g_tx_data);
        if (rst_n && pix_valid && pix_ready) pv = pv + 8'd1;
        cycle++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        pix_valid = 1'b1;
        tx_ready = 1'b1;
        #1;
        check(tx_valid == 1'b0, "R1 tx_valid in reset", int'(tx_valid), 0);
        check(stream_start == 1'b0, "R1 stream_start in reset", int'(stream_start), 0);
        check(pix_ready == 1'b0, "R10 pix_ready in reset", int'(pix_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        check(!tx_valid && !pix_ready && !stream_start, "R1 outputs after reset",
              int'({tx_valid, pix_ready, stream_start}), 0);
        check(pix_ready == 1'b0, "R10 pix_ready idle with pix_valid high", int'(pix_ready), 0);
    endtask

    task automatic t_param(input bit stall, input string tag);
        logic [7:0] exp_rgb[5];
        logic [7:0] exp_gray[5];
        int bad;
        exp_rgb  = '{8'hBB, 8'h00, 8'(W), 8'h00, 8'(H)};
        exp_gray = '{8'hAA, 8'h00, 8'(W), 8'h00, 8'(H)};
        stall_tx = stall;
        q.delete(); qg.delete();
        cyc(1'b1, 8'h01);
        idle(20);
        check(q.size() == 5, {"R2 packet length ", tag}, q.size(), 5);
        bad = 0;
        for (int i = 0; i < 5 && i < q.size(); i++)
            if (q[i] !== exp_rgb[i]) begin
                bad++;
                check(0, {"R2 packet byte ", tag}, int'(q[i]), int'(exp_rgb[i]));
            end
        check(bad == 0, {"R2 packet content ", tag}, bad, 0);
        check(q.size() > 0 && q[0] == 8'hBB, {"R3 rgb type byte ", tag}, q.size() > 0 ? int'(q[0]) : -1, 'hBB);
        check(qg.size() == 5 && qg[0] == exp_gray[0] && qg[2] == exp_gray[2] && qg[4] == exp_gray[4],
              {"R3 gray packet ", tag}, qg.size() > 0 ? int'(qg[0]) : -1, 'hAA);
        stall_tx = 0;
    endtask

    task automatic t_unknown();
        q.delete();
        cyc(1'b1, 8'h55);
        cyc(1'b1, 8'h10);
        cyc(1'b1, 8'h0f);
        idle(10);
        check(q.size() == 0, "R8 unknown bytes send nothing", q.size(), 0);
        check(stream_start == 1'b0, "R8 unknown bytes do not stream", int'(stream_start), 0);
    endtask

    task automatic t_param_drop();
        q.delete();
        cyc(1'b1, 8'h01);
        cyc(1'b1, 8'h11);
        cyc(1'b1, 8'h01);
        idle(15);
        check(q.size() == 5, "R8 commands during packet dropped (length)", q.size(), 5);
        check(stream_start == 1'b0, "R8 start during packet dropped", int'(stream_start), 0);
    endtask

    task automatic t_stream(input int stop_at, input bit stall, input bit gap, input bit extra, input string tag);
        logic [7:0] pv0;
        int nl, hdr_bad, pix_bad, pos, guard, after;
        bit sent, injected;
        stall_tx = stall;
        gap_pix = gap;
        q.delete();
        pv0 = pv;
        sent = 0;
        injected = 0;
        cyc(1'b1, 8'h11);
        cyc(1'b0, 8'h00);
        check(stream_start == 1'b1, {"R4 stream_start after start ", tag}, int'(stream_start), 1);
        guard = 0;
        while (guard < 4000 && !(sent && !stream_start)) begin
            if (!sent && q.size() >= stop_at) begin
                cyc(1'b1, 8'h0f);
                sent = 1;
            end else if (extra && !injected && q.size() >= 3) begin
                cyc(1'b1, 8'h01);
                cyc(1'b1, 8'h11);
                injected = 1;
            end else begin
                cyc(1'b0, 8'h00);
            end
            guard++;
        end
        after = q.size();
        idle(12);
        nl = stop_at / LINE_LEN + 1;
        check(q.size() == nl * LINE_LEN, {"R7 stream ends on line boundary ", tag}, q.size(), nl * LINE_LEN);
        check(q.size() == after && stream_start == 1'b0, {"R7 nothing after stop ", tag}, q.size(), after);
        hdr_bad = 0;
        pix_bad = 0;
        for (int l = 0; l < nl; l++) begin
            pos = l * LINE_LEN;
            if (pos + 1 < q.size()) begin
                if (q[pos] !== 8'h00 || q[pos+1] !== 8'(l % H)) begin
                    hdr_bad++;
                    check(0, {"R6 header value ", tag}, int'({q[pos], q[pos+1]}), l % H);
                end
            end
            for (int b = 0; b < BPL; b++)
                if (pos + 2 + b < q.size() && q[pos+2+b] !== 8'(pv0 + 8'(l * BPL + b))) pix_bad++;
        end
        check(hdr_bad == 0, {"R4 line headers ", tag}, hdr_bad, 0);
        check(pix_bad == 0, {"R5 pixel bytes in order ", tag}, pix_bad, 0);
        check(8'(pv - pv0) == 8'(nl * BPL), {"R9 pixels popped once each ", tag}, int'(8'(pv - pv0)), nl * BPL);
        stall_tx = 0;
        gap_pix = 0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_param(1'b0, "plain");
        t_param(1'b1, "stalled (R9)");
        t_unknown();
        t_param_drop();
        t_stream(17, 1'b0, 1'b0, 1'b0, "mid-line");
        t_stream(40, 1'b1, 1'b1, 1'b0, "stalls and wrap (R6 R9)");
        t_stream(30, 1'b0, 1'b1, 1'b1, "commands while streaming (R8)");
        t_stream(11, 1'b1, 1'b0, 1'b0, "stop near line end");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule